// File: doc/BRIEF.md
# Li-ion Linear Charger Control State Machine

This block is the digital sequencer behind a single-cell linear charger. The analog side supplies comparator flags: battery present, input supply valid, battery below the low-battery level, battery at the regulation level, charge current under the top-off level, two recharge comparators, the four temperature-zone flags and a die thermal-regulation flag. The block answers with a charge state, a 6-bit current setpoint code (5 mA per LSB, so 0 to 315 mA), a request to lower the constant-voltage target, a suspend flag, and one-cycle pulses for fault and completion.

A charge cycle runs from pre-charge through constant current and constant voltage into a timed top-off phase, then rests in a done state. It re-enters constant current when the battery sags. A pre-charge safety timer and a fast-charge safety timer bound the cycle. Temperature zones scale the setpoint or pause charging when thermistor monitoring is enabled. All timing counts pulses of an input `tick`, so the default parameters assume one tick per millisecond and a bench can shrink them.

Top module: `li_charger_ctrl`

## Requirements
- R1: After reset, and in IDLE, DONE and FAULT, `chg_state` is 0 (IDLE), 5 (DONE) or 6 (FAULT) respectively and `i_set`, `chg_suspend` and `cv_lower` are 0. The other codes are PRE=1, CC=2, CV=3, TOPOFF=4.
- R2: A new cycle whose battery is under the low-battery level enters PRE and drives `icode_pre`. On the first edge on which `vbat_low` is 0 it moves to CC.
- R3: In CC, on the first edge on which `vbat_at_reg` is 1 the state becomes CV. In CC, CV and TOPOFF the setpoint is `icode_cc`.
- R4: In CV, `ibat_below_topoff` moves the state to TOPOFF. After (`topoff_sel`+1)×TOPOFF_UNIT ticks in TOPOFF the state becomes DONE and `done_evt` pulses for one cycle.
- R5: In DONE, the recharge comparator chosen by `rechg_sel` (0: 140 mV offset, 1: 240 mV offset) must stay 1 for RECHG_TICKS consecutive ticks to return to CC. A shorter pulse, or the unselected comparator, leaves the state in DONE.
- R6: The safety timer limit is (`preq_sel`+1)×PREQ_UNIT ticks in PRE and (3+2×`fast_sel`)×FAST_UNIT ticks across CC and CV. It restarts on entry to PRE and to CC. On expiry the state becomes FAULT and `fault_evt` pulses.
- R7: With `ntc_en`=1 and the cold or hot flag set in an active charge state, `chg_suspend` is 1, `i_set` is 0, and both the state and the timers hold.
- R8: With `ntc_en`=1, the cool flag halves the setpoint and the warm flag sets `cv_lower`. With `ntc_en`=0, all zone flags have no effect.
- R9: Thermal regulation in CC halves the setpoint and makes the safety timer advance on every second tick.
- R10: Halving is a right shift with a floor of one LSB: a code of 1 stays 1, and 0 stays 0. Cool zone and thermal regulation together halve only once.
- R11: A cycle starts when `chg_en`, `bat_present` and `vin_ok` become all 1, whether by charge enable, battery attach or input attach. This includes a restart out of FAULT and the first edge after reset.
- R12: If `chg_en`, `bat_present` or `vin_ok` is 0, the state is IDLE on the next edge from any state, and all timers clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse that advances all timers |
| chg_en | input | 1 | Charging enabled |
| vin_ok | input | 1 | Valid input supply present |
| bat_present | input | 1 | Battery attached |
| vbat_low | input | 1 | Battery under low-battery level |
| vbat_at_reg | input | 1 | Battery at regulation voltage |
| ibat_below_topoff | input | 1 | Charge current under top-off level |
| vbat_below_rechg_lo | input | 1 | Battery under regulation minus 140 mV |
| vbat_below_rechg_hi | input | 1 | Battery under regulation minus 240 mV |
| zone_cold | input | 1 | Temperature below cold threshold |
| zone_cool | input | 1 | Temperature in cool band |
| zone_warm | input | 1 | Temperature in warm band |
| zone_hot | input | 1 | Temperature above hot threshold |
| therm_reg | input | 1 | Die thermal regulation active |
| ntc_en | input | 1 | Enables zone handling |
| icode_pre | input | ICODE_W | Pre-charge current code |
| icode_cc | input | ICODE_W | Fast-charge current code |
| topoff_sel | input | 2 | Top-off duration select |
| preq_sel | input | 2 | Pre-charge safety limit select |
| fast_sel | input | 2 | Fast-charge safety limit select |
| rechg_sel | input | 1 | Recharge offset select |
| chg_state | output | 3 | Current charge state |
| i_set | output | ICODE_W | Current setpoint code |
| cv_lower | output | 1 | Request lowered CV target |
| chg_suspend | output | 1 | Charging paused by temperature |
| fault_evt | output | 1 | One-cycle pulse on safety timeout |
| done_evt | output | 1 | One-cycle pulse on completion |

## Verification
On every cycle, assertions check several properties. A missing enable, battery or supply forces IDLE on the next edge. A temperature suspend freezes the state and zeroes the setpoint. The completion and fault pulses coincide with arrival in their states. PRE and CV are only left when their comparators allow it, and an active nonzero code never derates to zero. Only the directed scenarios can show the timing-dependent behaviour: the exact timer limits for each select value, the slowed safety timer under thermal regulation, the continuous-hold recharge deglitch with its offset choice, and the frozen timer during a suspend.

// File: rtl/lichg_pkg.sv
package lichg_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    CS_IDLE   = 3'd0,
    CS_PRE    = 3'd1,
    CS_CC     = 3'd2,
    CS_CV     = 3'd3,
    CS_TOPOFF = 3'd4,
    CS_DONE   = 3'd5,
    CS_FAULT  = 3'd6
  } chg_state_e;
endpackage

// File: rtl/lichg_timer.sv
module lichg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && cnt < limit) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/lichg_halver.sv
module lichg_halver #(
  parameter int W = 6
) (
  input  logic [W-1:0] code_in,
  input  logic         halve,
  output logic [W-1:0] code_out
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = code_in >> 1;
    if (!halve)              code_out = code_in;
    else if (shifted == '0)  code_out = code_in;
    else                     code_out = shifted;
  end
endmodule

// File: rtl/li_charger_ctrl.sv
module li_charger_ctrl
  import lichg_pkg::*;
#(
  parameter int ICODE_W     = 6,
  parameter int PREQ_UNIT   = 900000,
  parameter int FAST_UNIT   = 3600000,
  parameter int TOPOFF_UNIT = 600000,
  parameter int RECHG_TICKS = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               chg_en,
  input  logic               vin_ok,
  input  logic               bat_present,
  input  logic               vbat_low,
  input  logic               vbat_at_reg,
  input  logic               ibat_below_topoff,
  input  logic               vbat_below_rechg_lo,
  input  logic               vbat_below_rechg_hi,
  input  logic               zone_cold,
  input  logic               zone_cool,
  input  logic               zone_warm,
  input  logic               zone_hot,
  input  logic               therm_reg,
  input  logic               ntc_en,
  input  logic [ICODE_W-1:0] icode_pre,
  input  logic [ICODE_W-1:0] icode_cc,
  input  logic [1:0]         topoff_sel,
  input  logic [1:0]         preq_sel,
  input  logic [1:0]         fast_sel,
  input  logic               rechg_sel,
  output logic [2:0]         chg_state,
  output logic [ICODE_W-1:0] i_set,
  output logic               cv_lower,
  output logic               chg_suspend,
  output logic               fault_evt,
  output logic               done_evt
);
  localparam int PREQ_MAX = 4 * PREQ_UNIT;
  localparam int FAST_MAX = 9 * FAST_UNIT;
  localparam int SAFE_MAX = (PREQ_MAX > FAST_MAX) ? PREQ_MAX : FAST_MAX;
  localparam int SAFE_W   = $clog2(SAFE_MAX + 1);
  localparam int TOP_W    = $clog2(4 * TOPOFF_UNIT + 1);
  localparam int RCH_W    = $clog2(RECHG_TICKS + 1);

  chg_state_e state_q, state_d;
  logic fault_d, done_d;
  logic en_q, bat_q, vin_q;
  logic supply_ok, start_evt;
  logic active, safety_run, susp;

  // charge qualification and start detection
  assign supply_ok = chg_en && bat_present && vin_ok;
  assign start_evt = supply_ok && !(en_q && bat_q && vin_q);

  assign active     = (state_q == CS_PRE) || (state_q == CS_CC) ||
                      (state_q == CS_CV)  || (state_q == CS_TOPOFF);
  assign safety_run = (state_q == CS_PRE) || (state_q == CS_CC) ||
                      (state_q == CS_CV);
  assign susp       = active && ntc_en && (zone_cold || zone_hot);

  // safety timer: shared between pre-charge and fast-charge limits
  logic [SAFE_W-1:0] safe_lim;
  logic              safe_clr, safe_en, safe_exp, slow, phase_q;

  assign slow = therm_reg && (state_q == CS_CC);
  assign safe_lim = (state_q == CS_PRE)
                  ? SAFE_W'((int'(preq_sel) + 1) * PREQ_UNIT)
                  : SAFE_W'((3 + 2 * int'(fast_sel)) * FAST_UNIT);
  assign safe_clr = !safety_run ||
                    ((state_d == CS_PRE) && (state_q != CS_PRE)) ||
                    ((state_d == CS_CC)  && (state_q != CS_CC));
  assign safe_en  = tick && !susp && (!slow || phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_q <= 1'b0;
    else if (safe_clr || !slow)  phase_q <= 1'b0;
    else if (tick && !susp)      phase_q <= !phase_q;
  end

  lichg_timer #(.W(SAFE_W)) u_safe (
    .clk(clk), .rst_n(rst_n), .clr(safe_clr), .en(safe_en),
    .limit(safe_lim), .expired(safe_exp)
  );

  // top-off timer
  logic [TOP_W-1:0] top_lim;
  logic             top_exp;
  assign top_lim = TOP_W'((int'(topoff_sel) + 1) * TOPOFF_UNIT);

  lichg_timer #(.W(TOP_W)) u_topoff (
    .clk(clk), .rst_n(rst_n), .clr(state_q != CS_TOPOFF),
    .en(tick && !susp), .limit(top_lim), .expired(top_exp)
  );

  // recharge deglitch: selected comparator must hold continuously
  logic rechg_flag, rch_exp;
  assign rechg_flag = rechg_sel ? vbat_below_rechg_hi : vbat_below_rechg_lo;

  lichg_timer #(.W(RCH_W)) u_rechg (
    .clk(clk), .rst_n(rst_n), .clr((state_q != CS_DONE) || !rechg_flag),
    .en(tick), .limit(RCH_W'(RECHG_TICKS)), .expired(rch_exp)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    fault_d = 1'b0;
    done_d  = 1'b0;
    if (!supply_ok) begin
      state_d = CS_IDLE;
    end else if (start_evt) begin
      state_d = vbat_low ? CS_PRE : CS_CC;
    end else if (!susp) begin
      case (state_q)
        CS_PRE: begin
          if (safe_exp)       begin state_d = CS_FAULT; fault_d = 1'b1; end
          else if (!vbat_low) state_d = CS_CC;
        end
        CS_CC: begin
          if (safe_exp)         begin state_d = CS_FAULT; fault_d = 1'b1; end
          else if (vbat_at_reg) state_d = CS_CV;
        end
        CS_CV: begin
          if (safe_exp)               begin state_d = CS_FAULT; fault_d = 1'b1; end
          else if (ibat_below_topoff) state_d = CS_TOPOFF;
        end
        CS_TOPOFF: begin
          if (top_exp) begin state_d = CS_DONE; done_d = 1'b1; end
        end
        CS_DONE: begin
          if (rch_exp) state_d = CS_CC;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_IDLE;
      fault_evt <= 1'b0;
      done_evt  <= 1'b0;
      en_q      <= 1'b0;
      bat_q     <= 1'b0;
      vin_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      fault_evt <= fault_d;
      done_evt  <= done_d;
      en_q      <= chg_en;
      bat_q     <= bat_present;
      vin_q     <= vin_ok;
    end
  end

  // setpoint derating
  logic [ICODE_W-1:0] base_code, derated;
  logic               halve;
  assign base_code = (state_q == CS_PRE) ? icode_pre : icode_cc;
  assign halve     = (ntc_en && zone_cool) || slow;

  lichg_halver #(.W(ICODE_W)) u_halve (
    .code_in(base_code), .halve(halve), .code_out(derated)
  );

  assign chg_state   = state_q;
  assign i_set       = (active && !susp) ? derated : '0;
  assign chg_suspend = susp;
  assign cv_lower    = active && ntc_en && zone_warm;

  // assertions
  a_r12_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_en && bat_present && vin_ok) |=> (chg_state == CS_IDLE));

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_suspend && chg_en && bat_present && vin_ok) |=> $stable(chg_state));

  a_r7_zero_current: assert property (@(posedge clk) disable iff (!rst_n)
    chg_suspend |-> (i_set == '0));

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (chg_state == CS_DONE) && ($past(chg_state) == CS_TOPOFF));

  a_r6_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (chg_state == CS_FAULT));

  a_r2_pre_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_state == CS_CC) && ($past(chg_state) == CS_PRE)) |-> !$past(vbat_low));

  a_r3_cv_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_state == CS_CV) && ($past(chg_state) == CS_CC)) |-> $past(vbat_at_reg));

  a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !susp && (base_code != '0)) |-> (i_set != '0));
endmodule

// File: tb/tb_li_charger_ctrl.sv
module tb_li_charger_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick, chg_en, vin_ok, bat_present, vbat_low, vbat_at_reg;
  logic ibat_below_topoff, vbat_below_rechg_lo, vbat_below_rechg_hi;
  logic zone_cold, zone_cool, zone_warm, zone_hot, therm_reg, ntc_en, rechg_sel;
  logic [5:0] icode_pre, icode_cc, i_set;
  logic [1:0] topoff_sel, preq_sel, fast_sel;
  logic [2:0] chg_state;
  logic cv_lower, chg_suspend, fault_evt, done_evt;

  int vectors = 0;
  int fails = 0;
  int done_cnt = 0;
  int fault_cnt = 0;
  bit finished = 1'b0;

  li_charger_ctrl #(
    .ICODE_W(6), .PREQ_UNIT(10), .FAST_UNIT(10), .TOPOFF_UNIT(8), .RECHG_TICKS(6)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chg_en(chg_en), .vin_ok(vin_ok),
    .bat_present(bat_present), .vbat_low(vbat_low), .vbat_at_reg(vbat_at_reg),
    .ibat_below_topoff(ibat_below_topoff),
    .vbat_below_rechg_lo(vbat_below_rechg_lo), .vbat_below_rechg_hi(vbat_below_rechg_hi),
    .zone_cold(zone_cold), .zone_cool(zone_cool), .zone_warm(zone_warm),
    .zone_hot(zone_hot), .therm_reg(therm_reg), .ntc_en(ntc_en),
    .icode_pre(icode_pre), .icode_cc(icode_cc), .topoff_sel(topoff_sel),
    .preq_sel(preq_sel), .fast_sel(fast_sel), .rechg_sel(rechg_sel),
    .chg_state(chg_state), .i_set(i_set), .cv_lower(cv_lower),
    .chg_suspend(chg_suspend), .fault_evt(fault_evt), .done_evt(done_evt)
  );

  always @(negedge clk) begin
    if (done_evt)  done_cnt++;
    if (fault_evt) fault_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic restart();
    chg_en = 1'b0;
    step(1);
    chk("R12", "state after enable drop", chg_state, 0);
    chg_en = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    chk("R1", "reset state", chg_state, 0);
    chk("R1", "reset i_set", i_set, 0);
    chk("R1", "reset suspend", chg_suspend, 0);
    chk("R1", "reset cv_lower", cv_lower, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "idle without enable", chg_state, 0);
  endtask

  task automatic t_pre_to_cc();
    bat_present = 1'b1; vin_ok = 1'b1; vbat_low = 1'b1; chg_en = 1'b1;
    step(1);
    chk("R2", "enter PRE", chg_state, 1);
    chk("R2", "pre current", i_set, 12);
    vbat_low = 1'b0;
    step(1);
    chk("R2", "PRE to CC", chg_state, 2);
    chk("R3", "cc current", i_set, 40);
  endtask

  task automatic t_cv_topoff_done();
    vbat_at_reg = 1'b1;
    step(1);
    chk("R3", "CC to CV", chg_state, 3);
    chk("R3", "cv current", i_set, 40);
    ibat_below_topoff = 1'b1;
    step(1);
    chk("R4", "CV to TOPOFF", chg_state, 4);
    step(13);
    chk("R4", "topoff still running", chg_state, 4);
    step(6);
    chk("R4", "topoff expiry to DONE", chg_state, 5);
    chk("R4", "done pulse count", done_cnt, 1);
    chk("R1", "done i_set", i_set, 0);
  endtask

  task automatic t_recharge();
    vbat_at_reg = 1'b0; ibat_below_topoff = 1'b0;
    rechg_sel = 1'b1; vbat_below_rechg_lo = 1'b1; vbat_below_rechg_hi = 1'b0;
    step(12);
    chk("R5", "unselected comparator ignored", chg_state, 5);
    rechg_sel = 1'b0; vbat_below_rechg_lo = 1'b0;
    step(1);
    vbat_below_rechg_lo = 1'b1;
    step(3);
    vbat_below_rechg_lo = 1'b0;
    step(3);
    chk("R5", "short dip ignored", chg_state, 5);
    vbat_below_rechg_lo = 1'b1;
    step(10);
    chk("R5", "held dip recharges", chg_state, 2);
    vbat_below_rechg_lo = 1'b0;
  endtask

  task automatic t_fast_timeout();
    vbat_low = 1'b0; fast_sel = 2'd0;
    restart();
    chk("R11", "enable restart to CC", chg_state, 2);
    step(26);
    chk("R6", "fast timer not expired", chg_state, 2);
    step(6);
    chk("R6", "fast timer fault", chg_state, 6);
    chk("R6", "fault pulse count", fault_cnt, 1);
    chk("R1", "fault i_set", i_set, 0);
  endtask

  task automatic t_pre_timeout();
    vbat_low = 1'b1; preq_sel = 2'd1;
    restart();
    chk("R11", "restart into PRE", chg_state, 1);
    step(16);
    chk("R6", "pre timer not expired", chg_state, 1);
    step(6);
    chk("R6", "pre timer fault", chg_state, 6);
    chk("R6", "fault pulse count", fault_cnt, 2);
  endtask

  task automatic t_thermal();
    vbat_low = 1'b0; therm_reg = 1'b1;
    restart();
    chk("R9", "thermal halves cc", i_set, 20);
    step(44);
    chk("R9", "doubled timer still CC", chg_state, 2);
    step(20);
    chk("R9", "doubled timer fault", chg_state, 6);
  endtask

  task automatic t_floor();
    therm_reg = 1'b0; icode_cc = 6'd1;
    restart();
    therm_reg = 1'b1;
    #1;
    chk("R10", "code 1 floor", i_set, 1);
    icode_cc = 6'd0;
    #1;
    chk("R10", "code 0 stays 0", i_set, 0);
    icode_cc = 6'd63; ntc_en = 1'b1; zone_cool = 1'b1;
    #1;
    chk("R10", "single halving", i_set, 31);
    therm_reg = 1'b0;
    #1;
    chk("R8", "cool halves", i_set, 31);
    zone_cool = 1'b0; ntc_en = 1'b0; icode_cc = 6'd40;
  endtask

  task automatic t_jeita();
    restart();
    zone_cold = 1'b1;
    #1;
    chk("R8", "cold ignored ntc off suspend", chg_suspend, 0);
    chk("R8", "cold ignored ntc off i_set", i_set, 40);
    ntc_en = 1'b1;
    #1;
    chk("R7", "cold suspends", chg_suspend, 1);
    chk("R7", "cold zero current", i_set, 0);
    vbat_at_reg = 1'b1;
    step(5);
    chk("R7", "state frozen", chg_state, 2);
    zone_cold = 1'b0;
    step(1);
    chk("R7", "resume to CV", chg_state, 3);
    zone_warm = 1'b1;
    #1;
    chk("R8", "warm lowers CV", cv_lower, 1);
    ntc_en = 1'b0;
    #1;
    chk("R8", "warm ignored ntc off", cv_lower, 0);
    zone_warm = 1'b0;
  endtask

  task automatic t_suspend_timer();
    vbat_low = 1'b1; vbat_at_reg = 1'b0;
    restart();
    step(5);
    ntc_en = 1'b1; zone_hot = 1'b1;
    step(30);
    chk("R7", "hot keeps PRE", chg_state, 1);
    chk("R7", "hot suspend", chg_suspend, 1);
    zone_hot = 1'b0;
    step(8);
    chk("R7", "timer frozen during suspend", chg_state, 1);
    step(10);
    chk("R6", "timer resumes to fault", chg_state, 6);
    ntc_en = 1'b0;
  endtask

  task automatic t_start_events();
    vin_ok = 1'b0;
    step(1);
    chk("R12", "vin loss idle", chg_state, 0);
    vin_ok = 1'b1;
    step(1);
    chk("R11", "vin attach starts", chg_state, 1);
    bat_present = 1'b0;
    step(1);
    chk("R12", "battery removal idle", chg_state, 0);
    bat_present = 1'b1;
    step(1);
    chk("R11", "battery attach starts", chg_state, 1);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; chg_en = 1'b0; vin_ok = 1'b0; bat_present = 1'b0;
    vbat_low = 1'b0; vbat_at_reg = 1'b0; ibat_below_topoff = 1'b0;
    vbat_below_rechg_lo = 1'b0; vbat_below_rechg_hi = 1'b0;
    zone_cold = 1'b0; zone_cool = 1'b0; zone_warm = 1'b0; zone_hot = 1'b0;
    therm_reg = 1'b0; ntc_en = 1'b0; rechg_sel = 1'b0;
    icode_pre = 6'd12; icode_cc = 6'd40;
    topoff_sel = 2'd1; preq_sel = 2'd1; fast_sel = 2'd0;
    t_reset();
    t_pre_to_cc();
    t_cv_topoff_done();
    t_recharge();
    t_fast_timeout();
    t_pre_timeout();
    t_thermal();
    t_floor();
    t_jeita();
    t_suspend_timer();
    t_start_events();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule